// File: doc/BRIEF.md
# Status CSR Write-Legalizing Filter

This block holds the state behind a small group of control and status registers: the machine status word, a supervisor view of that word, the machine and supervisor interrupt pending and enable words, the supervisor trap vector, and the floating-point flag and rounding controls. A core's CSR unit hands it an address, write data and a write strobe. It returns the read value and an illegal-access flag in the same cycle. Fields that hold encodings take a written value only when that value is legal; otherwise the old contents are kept.

Two configuration inputs shape the behaviour. One selects a 64-bit or a 32-bit register width. The other says whether a custom extension is present. The width input sets which paging modes are legal, where the dirty-summary bit appears, and how much of the data path is live. The extension input decides whether the extension-state field can be written. Privilege checks on CSR access and trap entry belong to neighbouring logic.

Top module: `csr_legalize_filter`

## Requirements
- R1: The block implements these addresses: 0x001 flags, 0x002 rounding, 0x003 fp control, 0x100 supervisor status, 0x104 supervisor enable, 0x105 supervisor vector, 0x144 supervisor pending, 0x300 machine status, 0x304 machine enable, 0x344 machine pending.
- R2: After reset, machine status holds PL0=3 (machine) and PL1=PL2=1 (supervisor), with every other field 0. Every other register reads 0.
- R3: The machine status layout is: EN0 bit 0, PL0 [2:1], EN1 bit 3, PL1 [5:4], EN2 bit 6, PL2 [8:7], FST [10:9], XST [12:11], MOV bit 13, PGM [18:14], plus the dirty-summary bit at the top. EN0, EN1, EN2, MOV and FST take any written value.
- R4: A privilege field (PL0, PL1, PL2) takes a written value only when that value is 0 (user), 1 (supervisor) or 3 (machine). A write of 2 keeps the old value of that field.
- R5: PGM takes a written value only when the value is legal. Code 0 (bare) is legal at both widths. Codes 9 and 10 are legal in 64-bit mode. Code 8 is legal in 32-bit mode. Any other write keeps the old value.
- R6: XST takes a written value only while cfg_ext_en is 1.
- R7: The dirty-summary bit reads 1 when FST==3 or XST==3. It appears at bit 63 in 64-bit mode and at bit 31 in 32-bit mode, in both status views. Writes to it are ignored.
- R8: The supervisor status view shows EN0 at bit 0, EN1 at bit 3, PL1[0] at bit 4, FST [10:9], XST [12:11] and MOV bit 13. A write sets PL1 to {0, bit 4} and changes those same fields through the rules of R4 to R6, leaving PL0, PL2, EN2 and PGM unchanged.
- R9: The interrupt words use bit 1 for supervisor software, bit 3 for machine software and bit 5 for supervisor timer. A machine pending write changes bits 1 and 3. A machine enable write changes bits 1, 3 and 5.
- R10: A supervisor pending write changes only bit 1. A supervisor enable write changes only bits 1 and 5. Both supervisor reads show only bits 1 and 5 of the machine word.
- R11: A supervisor vector write stores the value with bits [1:0] cleared.
- R12: Flags holds 5 bits and rounding holds 3 bits. The fp control register reads {rounding, flags} in bits [7:0]. A write to it sets both fields, and a write to either single register sets only that field.
- R13: An access (csr_valid=1) to any other address raises csr_illegal in the same cycle, reads 0, and changes no state.
- R14: A write needs csr_valid and csr_we together and takes effect at the next rising clock edge. Reads are combinational. In 32-bit mode, write data bits [63:32] are ignored and read bits [63:32] are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | Access strobe |
| csr_we | input | 1 | Write enable, qualified by csr_valid |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, combinational |
| csr_illegal | output | 1 | Unimplemented address accessed |
| cfg_wide | input | 1 | 1 = 64-bit width, 0 = 32-bit width |
| cfg_ext_en | input | 1 | Extension present |

## Verification
Read data and the illegal flag depend only on the current address and the stored state, so they are due in the same cycle as the access. The bench samples them one time step after driving the inputs, with no clock edge in between. Write effects appear after one rising edge. Each write task therefore drives on a falling edge, releases on the next falling edge, and only then reads back, so every read-back lands exactly one edge after its write. Changes to the width and extension inputs are made between edges and act on the next access.

// File: rtl/csr_filt_pkg.sv
package csr_filt_pkg;

    localparam int XLEN_MAX = 64;
    localparam int HALF_W   = XLEN_MAX / 2;
    localparam int ADDR_W   = 12;

    localparam logic [ADDR_W-1:0] A_FP_FLAGS    = 12'h001;
    localparam logic [ADDR_W-1:0] A_FP_ROUND    = 12'h002;
    localparam logic [ADDR_W-1:0] A_FP_CTRL     = 12'h003;
    localparam logic [ADDR_W-1:0] A_SUP_STATUS  = 12'h100;
    localparam logic [ADDR_W-1:0] A_SUP_IEN     = 12'h104;
    localparam logic [ADDR_W-1:0] A_SUP_VEC     = 12'h105;
    localparam logic [ADDR_W-1:0] A_SUP_IPEND   = 12'h144;
    localparam logic [ADDR_W-1:0] A_MACH_STATUS = 12'h300;
    localparam logic [ADDR_W-1:0] A_MACH_IEN    = 12'h304;
    localparam logic [ADDR_W-1:0] A_MACH_IPEND  = 12'h344;

    // privilege codes
    localparam logic [1:0] PL_USER = 2'd0;
    localparam logic [1:0] PL_SUP  = 2'd1;
    localparam logic [1:0] PL_RSVD = 2'd2;
    localparam logic [1:0] PL_MACH = 2'd3;

    // paging mode codes
    localparam int         PGM_W  = 5;
    localparam logic [PGM_W-1:0] PG_OFF = 5'd0;
    localparam logic [PGM_W-1:0] PG_2L  = 5'd8;
    localparam logic [PGM_W-1:0] PG_3L  = 5'd9;
    localparam logic [PGM_W-1:0] PG_4L  = 5'd10;

    // status bit positions shared by both views
    localparam int P_EN0 = 0;
    localparam int P_EN1 = 3;
    localparam int P_PL1 = 4;
    localparam int P_FST = 9;
    localparam int P_XST = 11;
    localparam int P_MOV = 13;

    // interrupt bit positions
    localparam int B_SW_S = 1;
    localparam int B_SW_M = 3;
    localparam int B_TM_S = 5;

    localparam int FLG_W = 5;
    localparam int RND_W = 3;

    typedef struct packed {
        logic [PGM_W-1:0] pgm;
        logic             mov;
        logic [1:0]       xst;
        logic [1:0]       fst;
        logic [1:0]       pl2;
        logic             en2;
        logic [1:0]       pl1;
        logic             en1;
        logic [1:0]       pl0;
        logic             en0;
    } mstat_t;

    localparam int MS_W = $bits(mstat_t);

    typedef struct packed {
        logic tm_s;
        logic sw_m;
        logic sw_s;
    } ibits_t;

    typedef struct packed {
        logic fp_flags;
        logic fp_round;
        logic fp_ctrl;
        logic sup_status;
        logic sup_ien;
        logic sup_vec;
        logic sup_ipend;
        logic mach_status;
        logic mach_ien;
        logic mach_ipend;
    } sel_t;

    typedef struct packed {
        mstat_t              ms;
        ibits_t              ip;
        ibits_t              ie;
        logic [XLEN_MAX-1:0] vec;
        logic [RND_W-1:0]    rnd;
        logic [FLG_W-1:0]    flg;
    } st_t;

    localparam mstat_t MS_RESET = '{
        pgm: PG_OFF, mov: 1'b0, xst: 2'b00, fst: 2'b00,
        pl2: PL_SUP, en2: 1'b0, pl1: PL_SUP, en1: 1'b0,
        pl0: PL_MACH, en0: 1'b0
    };

    localparam st_t ST_RESET = '{
        ms: MS_RESET, ip: '0, ie: '0, vec: '0, rnd: '0, flg: '0
    };

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_filt_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    output sel_t          sel_o,
    output logic          hit_o
);

    always_comb begin
        sel_o = '0;
        case (addr_i)
            A_FP_FLAGS:    sel_o.fp_flags    = 1'b1;
            A_FP_ROUND:    sel_o.fp_round    = 1'b1;
            A_FP_CTRL:     sel_o.fp_ctrl     = 1'b1;
            A_SUP_STATUS:  sel_o.sup_status  = 1'b1;
            A_SUP_IEN:     sel_o.sup_ien     = 1'b1;
            A_SUP_VEC:     sel_o.sup_vec     = 1'b1;
            A_SUP_IPEND:   sel_o.sup_ipend   = 1'b1;
            A_MACH_STATUS: sel_o.mach_status = 1'b1;
            A_MACH_IEN:    sel_o.mach_ien    = 1'b1;
            A_MACH_IPEND:  sel_o.mach_ipend  = 1'b1;
            default:       sel_o = '0;
        endcase
        hit_o = |sel_o;
    end

endmodule

// File: rtl/csr_status_legalizer.sv
module csr_status_legalizer
    import csr_filt_pkg::*;
(
    input  mstat_t cur_i,
    input  mstat_t cand_i,
    input  logic   wide_i,
    input  logic   ext_en_i,
    output mstat_t nxt_o
);

    function automatic logic pl_ok(input logic [1:0] p);
        return p != PL_RSVD;
    endfunction

    function automatic logic pg_ok(input logic [PGM_W-1:0] m, input logic wide);
        logic ok;
        if (m == PG_OFF)
            ok = 1'b1;
        else if (wide)
            ok = (m == PG_3L) || (m == PG_4L);
        else
            ok = (m == PG_2L);
        return ok;
    endfunction

    always_comb begin
        nxt_o     = cur_i;
        // unconditionally writable fields
        nxt_o.en0 = cand_i.en0;
        nxt_o.en1 = cand_i.en1;
        nxt_o.en2 = cand_i.en2;
        nxt_o.mov = cand_i.mov;
        nxt_o.fst = cand_i.fst;
        // gated fields
        if (ext_en_i)
            nxt_o.xst = cand_i.xst;
        if (pl_ok(cand_i.pl0))
            nxt_o.pl0 = cand_i.pl0;
        if (pl_ok(cand_i.pl1))
            nxt_o.pl1 = cand_i.pl1;
        if (pl_ok(cand_i.pl2))
            nxt_o.pl2 = cand_i.pl2;
        if (pg_ok(cand_i.pgm, wide_i))
            nxt_o.pgm = cand_i.pgm;
    end

endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
    import csr_filt_pkg::*;
#(
    parameter int DW = XLEN_MAX
) (
    input  logic          en_i,
    input  sel_t          sel_i,
    input  st_t           st_i,
    input  logic          wide_i,
    output logic [DW-1:0] rdata_o
);

    localparam int HW = DW / 2;

    logic          dirty;
    logic [DW-1:0] m_view;
    logic [DW-1:0] s_view;
    logic [DW-1:0] ip_vec;
    logic [DW-1:0] ie_vec;
    logic [DW-1:0] val;

    always_comb begin
        dirty  = (st_i.ms.fst == 2'b11) || (st_i.ms.xst == 2'b11);

        m_view = {{(DW-MS_W){1'b0}}, st_i.ms};

        s_view                   = '0;
        s_view[P_EN0]            = st_i.ms.en0;
        s_view[P_EN1]            = st_i.ms.en1;
        s_view[P_PL1]            = st_i.ms.pl1[0];
        s_view[P_FST +: 2]       = st_i.ms.fst;
        s_view[P_XST +: 2]       = st_i.ms.xst;
        s_view[P_MOV]            = st_i.ms.mov;

        ip_vec         = '0;
        ip_vec[B_SW_S] = st_i.ip.sw_s;
        ip_vec[B_SW_M] = st_i.ip.sw_m;
        ip_vec[B_TM_S] = st_i.ip.tm_s;

        ie_vec         = '0;
        ie_vec[B_SW_S] = st_i.ie.sw_s;
        ie_vec[B_SW_M] = st_i.ie.sw_m;
        ie_vec[B_TM_S] = st_i.ie.tm_s;

        val = '0;
        unique case (1'b1)
            sel_i.mach_status: val = m_view;
            sel_i.sup_status:  val = s_view;
            sel_i.mach_ipend:  val = ip_vec;
            sel_i.mach_ien:    val = ie_vec;
            sel_i.sup_ipend: begin
                val[B_SW_S] = ip_vec[B_SW_S];
                val[B_TM_S] = ip_vec[B_TM_S];
            end
            sel_i.sup_ien: begin
                val[B_SW_S] = ie_vec[B_SW_S];
                val[B_TM_S] = ie_vec[B_TM_S];
            end
            sel_i.sup_vec:  val = st_i.vec;
            sel_i.fp_flags: val[FLG_W-1:0] = st_i.flg;
            sel_i.fp_round: val[RND_W-1:0] = st_i.rnd;
            sel_i.fp_ctrl:  val[FLG_W+RND_W-1:0] = {st_i.rnd, st_i.flg};
            default:        val = '0;
        endcase

        if (!wide_i)
            val[DW-1:HW] = '0;

        if (sel_i.mach_status || sel_i.sup_status) begin
            if (wide_i)
                val[DW-1] = dirty;
            else
                val[HW-1] = dirty;
        end

        rdata_o = en_i ? val : '0;
    end

endmodule

// File: rtl/csr_legalize_filter.sv
module csr_legalize_filter
    import csr_filt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = XLEN_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_valid,
    input  logic          csr_we,
    input  logic [AW-1:0] csr_addr,
    input  logic [DW-1:0] csr_wdata,
    output logic [DW-1:0] csr_rdata,
    output logic          csr_illegal,
    input  logic          cfg_wide,
    input  logic          cfg_ext_en
);

    localparam int HW = DW / 2;

    sel_t          sel;
    logic          hit;
    logic          do_wr;
    logic [DW-1:0] wval;
    mstat_t        ms_cand;
    mstat_t        ms_legal;
    st_t           st_d;
    st_t           st_q;

    csr_addr_decode #(.AW(AW)) u_dec (
        .addr_i (csr_addr),
        .sel_o  (sel),
        .hit_o  (hit)
    );

    csr_status_legalizer u_legal (
        .cur_i    (st_q.ms),
        .cand_i   (ms_cand),
        .wide_i   (cfg_wide),
        .ext_en_i (cfg_ext_en),
        .nxt_o    (ms_legal)
    );

    csr_read_mux #(.DW(DW)) u_rmux (
        .en_i    (csr_valid & hit),
        .sel_i   (sel),
        .st_i    (st_q),
        .wide_i  (cfg_wide),
        .rdata_o (csr_rdata)
    );

    assign csr_illegal = csr_valid & ~hit;

    // candidate status word from either view
    always_comb begin
        do_wr = csr_valid & csr_we & hit;
        wval  = cfg_wide ? csr_wdata : {{(DW-HW){1'b0}}, csr_wdata[HW-1:0]};
        if (sel.sup_status) begin
            ms_cand     = st_q.ms;
            ms_cand.en0 = wval[P_EN0];
            ms_cand.en1 = wval[P_EN1];
            ms_cand.pl1 = {1'b0, wval[P_PL1]};
            ms_cand.fst = wval[P_FST +: 2];
            ms_cand.xst = wval[P_XST +: 2];
            ms_cand.mov = wval[P_MOV];
        end else begin
            ms_cand = mstat_t'(wval[MS_W-1:0]);
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (do_wr) begin
            if (sel.mach_status || sel.sup_status)
                st_d.ms = ms_legal;
            if (sel.mach_ipend) begin
                st_d.ip.sw_s = wval[B_SW_S];
                st_d.ip.sw_m = wval[B_SW_M];
            end
            if (sel.mach_ien) begin
                st_d.ie.sw_s = wval[B_SW_S];
                st_d.ie.sw_m = wval[B_SW_M];
                st_d.ie.tm_s = wval[B_TM_S];
            end
            if (sel.sup_ipend)
                st_d.ip.sw_s = wval[B_SW_S];
            if (sel.sup_ien) begin
                st_d.ie.sw_s = wval[B_SW_S];
                st_d.ie.tm_s = wval[B_TM_S];
            end
            if (sel.sup_vec)
                st_d.vec = {wval[DW-1:2], 2'b00};
            if (sel.fp_flags)
                st_d.flg = wval[FLG_W-1:0];
            if (sel.fp_round)
                st_d.rnd = wval[RND_W-1:0];
            if (sel.fp_ctrl) begin
                st_d.flg = wval[FLG_W-1:0];
                st_d.rnd = wval[FLG_W +: RND_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_RESET;
        else
            st_q <= st_d;
    end

    // R4: no reserved privilege code is ever stored
    p_pl_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ms.pl0 != PL_RSVD) && (st_q.ms.pl1 != PL_RSVD) && (st_q.ms.pl2 != PL_RSVD));

    // R5: stored paging mode is always one of the defined codes
    p_pg_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ms.pgm == PG_OFF) || (st_q.ms.pgm == PG_2L) ||
        (st_q.ms.pgm == PG_3L) || (st_q.ms.pgm == PG_4L));

    // R6: without the extension the extension-state field holds
    p_xst_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ext_en |=> $stable(st_q.ms.xst));

    // R7: dirty summary appears at the top bit in 64-bit mode
    p_dsum_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && sel.mach_status && cfg_wide && st_q.ms.fst == 2'b11) |-> csr_rdata[DW-1]);

    // R9: the supervisor timer pending bit is never moved by a pending write
    p_tm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_we && (sel.mach_ipend || sel.sup_ipend)) |=> $stable(st_q.ip.tm_s));

    // R11: the vector stays aligned
    p_vec_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vec[1:0] == 2'b00);

    // R13: unknown address leaves state alone and reads zero
    p_illegal_keep_r13: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |=> $stable(st_q));
    p_illegal_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_rdata == '0);

    // R14: nothing changes without a qualified write
    p_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_valid && csr_we) |=> $stable(st_q));

endmodule

// File: tb/csr_legalize_filter_test.sv
module csr_legalize_filter_test;

    localparam logic [11:0] AF  = 12'h001, AR = 12'h002, AC = 12'h003;
    localparam logic [11:0] ASS = 12'h100, ASE = 12'h104, ASV = 12'h105, ASP = 12'h144;
    localparam logic [11:0] AMS = 12'h300, AME = 12'h304, AMP = 12'h344;
    localparam logic [11:0] ABAD = 12'h7C0;
    localparam logic [63:0] ONES = '1;
    localparam logic [63:0] TOP64 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] TOP32 = 64'h0000_0000_8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        csr_illegal;
    logic        cfg_wide = 1'b1;
    logic        cfg_ext_en = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    csr_legalize_filter uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_valid   (csr_valid),
        .csr_we      (csr_we),
        .csr_addr    (csr_addr),
        .csr_wdata   (csr_wdata),
        .csr_rdata   (csr_rdata),
        .csr_illegal (csr_illegal),
        .cfg_wide    (cfg_wide),
        .cfg_ext_en  (cfg_ext_en)
    );

    function automatic logic [63:0] msv(int e0, int p0, int e1, int p1, int e2, int p2,
                                        int fs, int xs, int mv, int pg);
        return 64'(e0) | (64'(p0) << 1) | (64'(e1) << 3) | (64'(p1) << 4) |
               (64'(e2) << 6) | (64'(p2) << 7) | (64'(fs) << 9) | (64'(xs) << 11) |
               (64'(mv) << 13) | (64'(pg) << 14);
    endfunction

    localparam logic [63:0] MSR = 64'h96;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_valid = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [63:0] exp);
        csr_valid = 1'b1; csr_we = 1'b0; csr_addr = a;
        #1;
        check(req, csr_rdata, exp);
        check(req, {63'b0, csr_illegal}, 64'd0);
        csr_valid = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R2 mach status", AMS, MSR);
        rd_chk("R2 sup status", ASS, 64'h10);
        rd_chk("R2 mach pend", AMP, 0);
        rd_chk("R2 mach en", AME, 0);
        rd_chk("R2 vector", ASV, 0);
        rd_chk("R2 fp ctrl", AC, 0);
    endtask

    task automatic t_paging;
        wr(AMS, msv(0,3,0,1,0,1,0,0,0,9));
        rd_chk("R5 wide code 9", AMS, msv(0,3,0,1,0,1,0,0,0,9));
        wr(AMS, msv(0,3,0,1,0,1,0,0,0,8));
        rd_chk("R5 wide rejects 8", AMS, msv(0,3,0,1,0,1,0,0,0,9));
        cfg_wide = 1'b0;
        wr(AMS, msv(0,3,0,1,0,1,0,0,0,8));
        rd_chk("R5 narrow code 8", AMS, msv(0,3,0,1,0,1,0,0,0,8));
        wr(AMS, msv(0,3,0,1,0,1,0,0,0,10));
        rd_chk("R5 narrow rejects 10", AMS, msv(0,3,0,1,0,1,0,0,0,8));
        wr(AMS, msv(0,3,0,1,0,1,0,0,0,0));
        rd_chk("R5 narrow bare", AMS, MSR);
        cfg_wide = 1'b1;
        wr(AMS, msv(0,3,0,1,0,1,0,0,0,10));
        rd_chk("R5 wide code 10", AMS, msv(0,3,0,1,0,1,0,0,0,10));
        wr(AMS, msv(0,3,0,1,0,1,0,0,0,5));
        rd_chk("R5 wide rejects 5", AMS, msv(0,3,0,1,0,1,0,0,0,10));
        wr(AMS, MSR);
        rd_chk("R5 wide bare", AMS, MSR);
    endtask

    task automatic t_priv;
        wr(AMS, msv(0,2,0,2,0,2,0,0,0,0));
        rd_chk("R4 reserved code kept old", AMS, MSR);
        wr(AMS, msv(0,0,0,3,0,0,0,0,0,0));
        rd_chk("R4 legal codes taken", AMS, msv(0,0,0,3,0,0,0,0,0,0));
        wr(AMS, MSR);
        rd_chk("R4 restore", AMS, MSR);
    endtask

    task automatic t_fields;
        wr(AMS, msv(1,3,1,1,1,1,1,3,1,0));
        rd_chk("R3 R6 free fields, ext state locked", AMS, msv(1,3,1,1,1,1,1,0,1,0));
        cfg_ext_en = 1'b1;
        wr(AMS, msv(1,3,1,1,1,1,1,2,1,0));
        rd_chk("R6 ext state with extension", AMS, msv(1,3,1,1,1,1,1,2,1,0));
        wr(AMS, MSR);
        rd_chk("R3 clear", AMS, MSR);
        cfg_ext_en = 1'b0;
    endtask

    task automatic t_dirty;
        wr(AMS, msv(0,3,0,1,0,1,3,0,0,0));
        rd_chk("R7 fp dirty wide", AMS, msv(0,3,0,1,0,1,3,0,0,0) | TOP64);
        rd_chk("R7 sup view wide", ASS, 64'h610 | TOP64);
        cfg_wide = 1'b0;
        rd_chk("R7 fp dirty narrow", AMS, msv(0,3,0,1,0,1,3,0,0,0) | TOP32);
        rd_chk("R7 sup view narrow", ASS, 64'h610 | TOP32);
        cfg_wide = 1'b1;
        cfg_ext_en = 1'b1;
        wr(AMS, msv(0,3,0,1,0,1,0,3,0,0));
        rd_chk("R7 ext dirty", AMS, msv(0,3,0,1,0,1,0,3,0,0) | TOP64);
        wr(AMS, MSR | TOP64);
        rd_chk("R7 summary not writable", AMS, MSR);
        cfg_ext_en = 1'b0;
    endtask

    task automatic t_sup_view;
        wr(ASS, 64'h1 | 64'h8 | 64'h10 | (64'd2 << 9) | (64'd3 << 11) | (64'd1 << 13) | 64'h46);
        rd_chk("R8 mach after sup write", AMS, msv(1,3,1,1,0,1,2,0,1,0));
        rd_chk("R8 sup view read", ASS, 64'h1 | 64'h8 | 64'h10 | (64'd2 << 9) | (64'd1 << 13));
        wr(ASS, 64'h0);
        rd_chk("R8 sup write clears PL1", AMS, msv(0,3,0,0,0,1,0,0,0,0));
        rd_chk("R8 sup view zero", ASS, 64'h0);
        wr(AMS, MSR);
    endtask

    task automatic t_intr;
        wr(AMP, ONES);
        rd_chk("R9 mach pend mask", AMP, 64'h0A);
        wr(AME, ONES);
        rd_chk("R9 mach en mask", AME, 64'h2A);
        rd_chk("R10 sup pend read", ASP, 64'h02);
        rd_chk("R10 sup en read", ASE, 64'h22);
        wr(AMP, 64'h08);
        wr(ASP, ONES);
        rd_chk("R10 sup pend write", AMP, 64'h0A);
        wr(ASP, 64'h0);
        rd_chk("R10 sup pend keeps machine bit", AMP, 64'h08);
        wr(AME, 64'h08);
        wr(ASE, ONES);
        rd_chk("R10 sup en write", AME, 64'h2A);
        wr(ASE, 64'h0);
        rd_chk("R10 sup en clear", AME, 64'h08);
    endtask

    task automatic t_vec;
        wr(ASV, ONES);
        rd_chk("R11 aligned wide", ASV, 64'hFFFF_FFFF_FFFF_FFFC);
        cfg_wide = 1'b0;
        rd_chk("R14 narrow read upper zero", ASV, 64'h0000_0000_FFFF_FFFC);
        wr(ASV, 64'hFFFF_FFFF_1234_5677);
        cfg_wide = 1'b1;
        rd_chk("R14 narrow write drops upper", ASV, 64'h0000_0000_1234_5674);
    endtask

    task automatic t_fp;
        wr(AC, 64'hFF);
        rd_chk("R12 flags from ctrl", AF, 64'h1F);
        rd_chk("R12 round from ctrl", AR, 64'h07);
        rd_chk("R12 ctrl", AC, 64'hFF);
        wr(AR, 64'hFA);
        rd_chk("R12 round alone", AC, 64'h5F);
        wr(AF, 64'h60);
        rd_chk("R12 flags alone", AC, 64'h40);
    endtask

    task automatic t_illegal;
        csr_valid = 1'b1; csr_we = 1'b0; csr_addr = ABAD;
        #1;
        check("R13 flag raised", {63'b0, csr_illegal}, 64'd1);
        check("R13 reads zero", csr_rdata, 64'd0);
        csr_valid = 1'b0;
        rd_chk("R1 implemented address not flagged", AMS, MSR);
        wr(ABAD, ONES);
        rd_chk("R13 status kept", AMS, MSR);
        rd_chk("R13 vector kept", ASV, 64'h1234_5674);
        rd_chk("R13 fp kept", AC, 64'h40);
        rd_chk("R13 pend kept", AMP, 64'h08);
    endtask

    task automatic t_quiet;
        @(negedge clk);
        csr_valid = 1'b1; csr_we = 1'b0; csr_addr = AMS; csr_wdata = 64'h0;
        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
        rd_chk("R14 no write without strobe", AMS, MSR);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_paging;
        t_priv;
        t_fields;
        t_dirty;
        t_sup_view;
        t_intr;
        t_vec;
        t_fp;
        t_illegal;
        t_quiet;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule